// File: doc/BRIEF.md
# Addressed Serial Register Front End

This block is the serial slave side of a small I/O expander. A host talks to it over a four-wire serial link in clock mode 0, most significant bit first, with an active-low select. Up to eight such expanders can hang off one select line. Each one compares a 3-bit device number carried in the opening byte of a frame with its own strapped address, and only the matching device takes part in the frame.

A frame has three parts. It opens with a command byte, then comes a register pointer byte, then any number of data bytes. On the inside, the block drives a simple register bus to the expander's register file. That bus has an address, write data, a one-cycle write strobe, a one-cycle read strobe, and a read-data return. Some registers change state when they are read, which is why every byte fetched for shifting out is announced with the read strobe.

Two configuration bits come in from the register file. One decides whether the device number is checked at all. The other freezes the register pointer, so that repeated bytes in a frame keep targeting the same register instead of stepping through the map.

Top module: `spi_reg_front`

## Requirements
- R1: Command byte layout: bits 7..4 must equal 4'b0100, bits 3..1 hold the device number, and bit 0 selects the direction (1 = read, 0 = write). A command byte with any other upper nibble makes the device ignore the rest of the frame: it produces no strobes and keeps `spi_miso_oe` low.
- R2: When `cfg_haen` is 1, the device answers only if command bits 3..1 equal `hw_addr`. When `cfg_haen` is 0, it answers whatever those bits hold.
- R3: In an addressed write frame, each complete data byte produces exactly one `reg_we` pulse. That pulse carries the current pointer on `reg_addr` and the received byte on `reg_wdata`. The second byte of the frame sets the pointer's starting value.
- R4: When `cfg_seq_hold` is 0, the pointer advances by one after each data byte, and it wraps from `REG_LAST` (default 8'h0A) back to 8'h00.
- R5: When `cfg_seq_hold` is 1, the pointer stays unchanged for the whole frame.
- R6: In an addressed read frame, `reg_re` pulses for one cycle with the register address at the end of the pointer byte and again after each data byte, fetching the next register. Each fetched byte is shifted out MSB first, changing after falling clock edges.
- R7: `spi_miso_oe` is 1 only while select is low, during the data phase of an addressed read frame. It is 0 in write frames, in unaddressed frames, and in the command and pointer phases.
- R8: A rising edge on `spi_csn` ends the frame at once and clears the bit counter. Any partly received byte is dropped and produces no strobe, and the next frame starts cleanly with a command byte.
- R9: After reset, `reg_we`, `reg_re` and `spi_miso_oe` are all 0.
- R10: `reg_we` and `reg_re` are never high together, and each is high for a single cycle at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; serial inputs are oversampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_csn | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Output enable for the serial data pad |
| hw_addr | input | 3 | Strapped device number |
| cfg_haen | input | 1 | Device-number checking enable |
| cfg_seq_hold | input | 1 | 1 holds the pointer, 0 auto-increments it |
| reg_addr | output | 8 | Register bus address |
| reg_wdata | output | 8 | Register bus write data |
| reg_we | output | 1 | One-cycle write strobe |
| reg_re | output | 1 | One-cycle read strobe (fetch for shift-out) |
| reg_rdata | input | 8 | Read data, valid in the cycle `reg_re` is high |

## Verification
The embedded properties check these rules on every cycle:
- the two strobes never overlap and never stretch past one cycle;
- a write strobe only occurs in a write data phase;
- the pad enable only rises while select is low;
- a deasserted select returns the frame to the command phase;
- the pointer either holds or wraps at the last register as configured.

Some behaviour can only be shown by the bench's frames, which compare the register bus and shifted-out bytes against its own model:
- which exact addresses and data reach the bus;
- the bit order of the returned bytes;
- device-number filtering and opcode rejection;
- the extra prefetch at the end of a read;
- dropping of partial bytes.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;

  localparam int          BYTE_W = 8;
  localparam logic [3:0]  OPCODE = 4'b0100;

  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_PTR  = 2'd1,
    PH_DATA = 2'd2,
    PH_SKIP = 2'd3
  } phase_e;

  // Does a command byte select this device?
  function automatic logic cmd_hits(input logic [BYTE_W-1:0] cmd,
                                    input logic [2:0]        dev,
                                    input logic              check_dev);
    logic op_ok;
    logic dev_ok;
    op_ok  = (cmd[7:4] == OPCODE);
    dev_ok = !check_dev || (cmd[3:1] == dev);
    return op_ok && dev_ok;
  endfunction

  // Pointer after one data byte.
  function automatic logic [BYTE_W-1:0] ptr_step(input logic [BYTE_W-1:0] p,
                                                 input logic              hold,
                                                 input logic [BYTE_W-1:0] last);
    if (hold)       return p;
    if (p >= last)  return '0;
    return p + 1'b1;
  endfunction

endpackage

// File: rtl/spi_rf_sync.sv
module spi_rf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic csn_i,
  input  logic mosi_i,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_act,
  output logic cs_rise,
  output logic mosi_s
);
  // lane order {mosi, csn, sclk}
  localparam logic [2:0] IDLE_V = 3'b010;
  localparam int         LAST   = STAGES - 1;

  logic [2:0] pipe [STAGES];
  logic [2:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= IDLE_V;
      prev <= IDLE_V;
    end else begin
      pipe[0] <= {mosi_i, csn_i, sclk_i};
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      prev <= pipe[LAST];
    end
  end

  assign sclk_rise = pipe[LAST][0] && !prev[0];
  assign sclk_fall = !pipe[LAST][0] && prev[0];
  assign cs_act    = !pipe[LAST][1];
  assign cs_rise   = pipe[LAST][1] && !prev[1];
  assign mosi_s    = pipe[LAST][2];
endmodule

// File: rtl/spi_rf_shift.sv
module spi_rf_shift
  import spi_rf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              cs_act,
  input  logic              mosi_s,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_data,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              byte_done,
  output logic              tx_bit
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] rx_sr;
  logic [BYTE_W-1:0] tx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      rx_sr     <= '0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (!cs_act) begin
        bit_cnt <= '0;
      end else if (sclk_rise) begin
        rx_sr     <= {rx_sr[BYTE_W-2:0], mosi_s};
        bit_cnt   <= bit_cnt + 1'b1;
        byte_done <= (bit_cnt == CNT_LAST);
      end
    end
  end

  // Shift only on falling edges inside a byte; the fall that follows
  // the last bit of a byte leaves the freshly loaded MSB in place.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr <= '0;
    end else if (load) begin
      tx_sr <= load_data;
    end else if (cs_act && sclk_fall && bit_cnt != '0) begin
      tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
    end
  end

  assign rx_byte = rx_sr;
  assign tx_bit  = tx_sr[BYTE_W-1];

  p_done_in_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> $past(cs_act));
endmodule

// File: rtl/spi_rf_frame.sv
module spi_rf_frame
  import spi_rf_pkg::*;
#(
  parameter logic [BYTE_W-1:0] REG_LAST = 8'h0A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [2:0]        hw_addr,
  input  logic              cfg_haen,
  input  logic              cfg_seq_hold,
  output logic [BYTE_W-1:0] reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_we,
  output logic              reg_re,
  output logic              drive_out
);
  phase_e            phase;
  logic              rd_q;
  logic [BYTE_W-1:0] ptr;
  logic [BYTE_W-1:0] ptr_nx;

  assign ptr_nx = ptr_step(ptr, cfg_seq_hold, REG_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_CMD;
      rd_q      <= 1'b0;
      ptr       <= '0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      reg_we    <= 1'b0;
      reg_re    <= 1'b0;
    end else begin
      reg_we <= 1'b0;
      reg_re <= 1'b0;
      if (!cs_act) begin
        phase <= PH_CMD;
        rd_q  <= 1'b0;
      end else if (byte_done) begin
        unique case (phase)
          PH_CMD: begin
            if (cmd_hits(rx_byte, hw_addr, cfg_haen)) begin
              rd_q  <= rx_byte[0];
              phase <= PH_PTR;
            end else begin
              phase <= PH_SKIP;
            end
          end
          PH_PTR: begin
            ptr   <= rx_byte;
            phase <= PH_DATA;
            if (rd_q) begin
              reg_re   <= 1'b1;
              reg_addr <= rx_byte;
            end
          end
          PH_DATA: begin
            ptr <= ptr_nx;
            if (rd_q) begin
              reg_re   <= 1'b1;
              reg_addr <= ptr_nx;
            end else begin
              reg_we    <= 1'b1;
              reg_addr  <= ptr;
              reg_wdata <= rx_byte;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign drive_out = cs_act && rd_q && (phase == PH_DATA);

  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_re));
  p_we_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);
  p_re_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |=> !reg_re);
  p_we_in_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (phase == PH_DATA && !rd_q));
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && byte_done && phase == PH_DATA && cfg_seq_hold) |=> (ptr == $past(ptr)));
  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && byte_done && phase == PH_DATA && !cfg_seq_hold && ptr == REG_LAST) |=> (ptr == '0));
  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (phase == PH_CMD && !reg_we && !reg_re));
endmodule

// File: rtl/spi_reg_front.sv
module spi_reg_front
  import spi_rf_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [BYTE_W-1:0] REG_LAST    = 8'h0A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_csn,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  input  logic [2:0]        hw_addr,
  input  logic              cfg_haen,
  input  logic              cfg_seq_hold,
  output logic [BYTE_W-1:0] reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_we,
  output logic              reg_re,
  input  logic [BYTE_W-1:0] reg_rdata
);
  // named internal events
  logic              sclk_rise;
  logic              sclk_fall;
  logic              cs_act;
  logic              cs_rise;
  logic              mosi_s;
  logic              byte_done;
  logic [BYTE_W-1:0] rx_byte;
  logic              tx_bit;
  logic              drive_out;

  spi_rf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_i    (spi_sclk),
    .csn_i     (spi_csn),
    .mosi_i    (spi_mosi),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .cs_act    (cs_act),
    .cs_rise   (cs_rise),
    .mosi_s    (mosi_s)
  );

  spi_rf_shift u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .cs_act    (cs_act),
    .mosi_s    (mosi_s),
    .load      (reg_re),
    .load_data (reg_rdata),
    .rx_byte   (rx_byte),
    .byte_done (byte_done),
    .tx_bit    (tx_bit)
  );

  spi_rf_frame #(.REG_LAST(REG_LAST)) u_frame (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_act       (cs_act),
    .byte_done    (byte_done),
    .rx_byte      (rx_byte),
    .hw_addr      (hw_addr),
    .cfg_haen     (cfg_haen),
    .cfg_seq_hold (cfg_seq_hold),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_we       (reg_we),
    .reg_re       (reg_re),
    .drive_out    (drive_out)
  );

  assign spi_miso    = tx_bit;
  assign spi_miso_oe = drive_out;

  p_oe_needs_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    spi_miso_oe |-> cs_act);
  p_oe_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |-> !spi_miso_oe);
  p_no_done_on_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !byte_done);
endmodule

// File: tb/tb_spi_reg_front.sv
module tb_spi_reg_front;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       spi_sclk = 1'b0;
  logic       spi_csn = 1'b1;
  logic       spi_mosi = 1'b0;
  logic       spi_miso;
  logic       spi_miso_oe;
  logic [2:0] hw_addr = 3'd5;
  logic       cfg_haen = 1'b1;
  logic       cfg_seq_hold = 1'b0;
  logic [7:0] reg_addr;
  logic [7:0] reg_wdata;
  logic       reg_we;
  logic       reg_re;
  logic [7:0] reg_rdata;

  int vectors = 0;
  int misses  = 0;

  typedef struct {
    bit         is_we;
    logic [7:0] addr;
    logic [7:0] data;
    string      tag;
  } ev_t;
  ev_t evq[$];

  logic [7:0] wbuf [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] rd_model(input logic [7:0] a);
    return (a * 8'd37) ^ 8'h5C;
  endfunction
  assign reg_rdata = rd_model(reg_addr);

  spi_reg_front dut (
    .clk(clk), .rst_n(rst_n),
    .spi_sclk(spi_sclk), .spi_csn(spi_csn), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .hw_addr(hw_addr), .cfg_haen(cfg_haen), .cfg_seq_hold(cfg_seq_hold),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Bench view of the rules, written from the requirements.
  function automatic bit selects(input logic [7:0] cmd);
    bit op = (cmd >> 4) == 8'h04;
    bit dv = !cfg_haen || (((cmd >> 1) & 8'h07) == {5'd0, hw_addr});
    return op && dv;
  endfunction

  function automatic logic [7:0] advance(input logic [7:0] p);
    if (cfg_seq_hold) return p;
    return (p < 8'd10) ? p + 8'd1 : 8'd0;
  endfunction

  // Monitor: pop one expected bus event per observed strobe.
  always @(negedge clk) begin
    if (rst_n && (reg_we || reg_re)) begin
      if (evq.size() == 0) begin
        check(1'b0, "R1", "unexpected strobe addr", reg_addr, 8'h00);
      end else begin
        ev_t e;
        e = evq.pop_front();
        check(e.is_we == reg_we && e.is_we != reg_re, e.tag, "strobe kind",
              {7'd0, reg_we}, {7'd0, e.is_we});
        check(reg_addr == e.addr, e.tag, "bus address", reg_addr, e.addr);
        if (e.is_we)
          check(reg_wdata == e.data, e.tag, "write data", reg_wdata, e.data);
      end
    end
  end

  task automatic xfer(input logic [7:0] tx, input bit chk_rx,
                      input logic [7:0] exp_rx, input bit exp_oe,
                      input string tag, input int nbits);
    logic [7:0] got = '0;
    for (int b = 7; b >= 8 - nbits; b--) begin
      spi_mosi = tx[b];
      repeat (HALF) @(negedge clk);
      if (b == 7)
        check(spi_miso_oe == exp_oe, (exp_oe ? tag : "R7"), "pad enable",
              {7'd0, spi_miso_oe}, {7'd0, exp_oe});
      got = {got[6:0], spi_miso};
      spi_sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sclk = 1'b0;
    end
    if (chk_rx) check(got == exp_rx, "R6", "shifted byte", got, exp_rx);
  endtask

  task automatic frame(input logic [7:0] cmd, input logic [7:0] ptr,
                       input int n, input int tail, input string tag);
    bit         hit = selects(cmd);
    bit         rd  = cmd[0];
    logic [7:0] p   = ptr;
    logic [7:0] exp_rd [16];
    ev_t        e;
    if (hit && rd) begin
      e = '{1'b0, p, 8'h00, tag}; evq.push_back(e);
    end
    for (int k = 0; k < n; k++) begin
      if (hit && !rd) begin
        e = '{1'b1, p, wbuf[k], tag}; evq.push_back(e);
      end
      exp_rd[k] = rd_model(p);
      p = advance(p);
      if (hit && rd) begin
        e = '{1'b0, p, 8'h00, tag}; evq.push_back(e);
      end
    end
    @(negedge clk);
    spi_csn = 1'b0;
    repeat (HALF) @(negedge clk);
    xfer(cmd, 1'b0, 8'h00, 1'b0, tag, 8);
    xfer(ptr, 1'b0, 8'h00, 1'b0, tag, 8);
    for (int k = 0; k < n; k++)
      xfer(rd ? 8'h00 : wbuf[k], hit && rd, exp_rd[k], hit && rd, tag, 8);
    if (tail > 0)
      xfer(8'hA5, 1'b0, 8'h00, hit && rd, tag, tail);
    repeat (HALF) @(negedge clk);
    spi_csn = 1'b1;
    repeat (4 * HALF) @(negedge clk);
    check(evq.size() == 0, tag, "events left after frame",
          8'(evq.size()), 8'h00);
    evq.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    misses++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) wbuf[i] = 8'(8'h11 * (i + 1) ^ 8'h80);
    repeat (5) @(negedge clk);
    // R9: reset state
    check(reg_we == 1'b0, "R9", "we after reset", {7'd0, reg_we}, 8'h00);
    check(reg_re == 1'b0, "R9", "re after reset", {7'd0, reg_re}, 8'h00);
    check(spi_miso_oe == 1'b0, "R9", "oe in reset", {7'd0, spi_miso_oe}, 8'h00);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(reg_we == 1'b0 && reg_re == 1'b0, "R9", "strobes idle after release",
          {6'd0, reg_we, reg_re}, 8'h00);
    check(spi_miso_oe == 1'b0, "R9", "oe idle after release",
          {7'd0, spi_miso_oe}, 8'h00);

    // R3 R4: addressed write, three bytes from 2
    frame(8'h4A, 8'h02, 3, 0, "R3");
    // R4: write wraps past the last register (9, 10, 0)
    frame(8'h4A, 8'h09, 3, 0, "R4");
    // R6: addressed read, two bytes from 4
    frame(8'h4B, 8'h04, 2, 0, "R6");
    // R4: read wraps (10, 0) with prefetch of 1
    frame(8'h4B, 8'h0A, 2, 0, "R4");
    // R2: other device number ignored for write and read
    frame(8'h44, 8'h01, 2, 0, "R2");
    frame(8'h43, 8'h01, 2, 0, "R2");
    // R2: checking disabled, any number answers
    cfg_haen = 1'b0;
    frame(8'h42, 8'h06, 2, 0, "R2");
    frame(8'h4F, 8'h03, 1, 0, "R2");
    cfg_haen = 1'b1;
    // R1: wrong opcode nibble, both directions
    frame(8'h5A, 8'h01, 2, 0, "R1");
    frame(8'hCB, 8'h01, 2, 0, "R1");
    // R5: pointer held in both directions
    cfg_seq_hold = 1'b1;
    frame(8'h4A, 8'h07, 3, 0, "R5");
    frame(8'h4B, 8'h03, 2, 0, "R5");
    cfg_seq_hold = 1'b0;
    // R8: partial trailing byte dropped
    frame(8'h4A, 8'h05, 1, 5, "R8");
    // R8: abort inside the command byte, then a clean frame
    @(negedge clk);
    spi_csn = 1'b0;
    repeat (HALF) @(negedge clk);
    xfer(8'h4A, 1'b0, 8'h00, 1'b0, "R8", 4);
    spi_csn = 1'b1;
    repeat (4 * HALF) @(negedge clk);
    check(evq.size() == 0 && !spi_miso_oe, "R8", "abort leaves idle",
          {7'd0, spi_miso_oe}, 8'h00);
    frame(8'h4B, 8'h08, 1, 0, "R8");
    // R7: select released leaves pad disabled
    check(spi_miso_oe == 1'b0, "R7", "oe after frame", {7'd0, spi_miso_oe}, 8'h00);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule